// File: doc/BRIEF.md
# Biphase-Mark Transmit Frame Serializer

This block turns a stream of symbols into the cell sequence of one biphase-mark-coded frame. It drives the line at one half-bit cell per pulse of a cell-rate enable, which runs at twice the data rate (600 kHz cells for a 300 kbit/s link). A frame opens with a fixed 128-cell alternating preamble. It then carries any number of 10-cell symbol patterns, each already expanded from a 5-bit line code by the logic upstream. It closes with a short edge-and-trailer sequence, after which the line is released.

The symbol patterns arrive with the level of their first half-cell undefined. The block keeps a running polarity mask so that the line level never jumps at a symbol boundary. A pattern that follows a high cell is inverted, and the mask for the next pattern comes from the last cell actually sent. A frame request that arrives while the receiver reports activity on the line is refused, so the block never talks over an incoming frame.

Top module: `bmc_tx_serializer`

## Requirements
- R1: After reset, tx_line_o, tx_oe_o, sym_ready_o and start_rej_o are all 0.
- R2: A start_i pulse seen while idle with rx_busy_i high is refused. start_rej_o is 1 for exactly the following cycle, and tx_oe_o stays 0 with no cell driven.
- R3: An accepted frame begins with 128 preamble cells. Cell k is bit (k mod 8) of 8'hB4, so the line runs 0,0,1,0,1,1,0,1 repeated, starting low and ending high. tx_oe_o rises on the tick that drives the first preamble cell.
- R4: sym_ready_o is 0 during the preamble. It rises only once the preamble is complete and no symbol is held. It drops in the cycle after a handshake (sym_valid_i and sym_ready_o both 1) and stays low until all 10 cells of that symbol have been driven.
- R5: Each accepted 10-bit pattern is XORed with the polarity mask and sent with bit 0 first, one bit per tick. The mask is all ones for the first symbol after the preamble.
- R6: After each symbol the mask becomes all ones if bit 9 of the transmitted (XORed) pattern is 1, and all zeros otherwise.
- R7: An end request (eof_i) is taken when no symbol is held. The closing sequence is then three cells: 1,1,0 if the last cell sent was low, and 0,0,0 if it was high (this includes a frame with no symbols).
- R8: tx_oe_o falls on the first tick after the third closing cell, with tx_line_o at 0. The block is then idle, and sym_ready_o stays 0.
- R9: tx_line_o changes only in the cycle after a cycle in which cell_tick_i is high.
- R10: When sym_valid_i and eof_i are both high while ready, the symbol is taken first and the frame closes after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cell_tick_i | input | 1 | One-cycle enable, one pulse per half-bit cell |
| rx_busy_i | input | 1 | Receiver is currently taking in a frame |
| start_i | input | 1 | Request to begin a frame |
| start_rej_o | output | 1 | One-cycle pulse: start refused because of receive activity |
| sym_valid_i | input | 1 | Symbol pattern available |
| sym_cells_i | input | 10 | Pre-expanded cell pattern, bit 0 sent first |
| sym_ready_o | output | 1 | Symbol can be taken this cycle |
| eof_i | input | 1 | Request to close the frame after the last symbol |
| tx_line_o | output | 1 | Serial line level |
| tx_oe_o | output | 1 | Line driver enable, low releases the line |

## Verification
The assertions assume that cell_tick_i is a single-cycle pulse and that ticks are at least a few cycles apart, so that a handshake offered right after ready rises lands before the next tick. They also assume that start_i is only pulsed while the block is idle. The stimulus produces a tick every fourth clock and keeps sym_valid_i raised before ready can rise, so no symbol underruns and no tick is missed. It also holds eof_i until the line has been released, and it raises rx_busy_i only around the refused-start scenario.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYM  = 2'd2,
    ST_TAIL = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bmc_tx_preamble.sv
module bmc_tx_preamble #(
  parameter int          CNT_W = 8,
  parameter int          PAT_W = 8,
  parameter logic [7:0]  PAT   = 8'hB4
) (
  input  logic [CNT_W-1:0] idx_i,
  output logic             cell_o
);
  localparam int SEL_W = $clog2(PAT_W);

  logic [SEL_W-1:0] sel;

  // pattern repeats every PAT_W cells, low bits of the index select the cell
  assign sel    = idx_i[SEL_W-1:0];
  assign cell_o = PAT[sel];
endmodule

// File: rtl/bmc_tx_polarity.sv
module bmc_tx_polarity #(
  parameter int SYM_CELLS = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 arm_i,
  input  logic                 load_i,
  input  logic [SYM_CELLS-1:0] raw_i,
  output logic [SYM_CELLS-1:0] cells_o,
  output logic                 last_hi_o
);
  logic [SYM_CELLS-1:0] mask_q, mask_d;

  assign cells_o   = raw_i ^ mask_q;
  assign last_hi_o = mask_q[0];

  always_comb begin
    mask_d = mask_q;
    if (arm_i) begin
      mask_d = '1;
    end else if (load_i) begin
      mask_d = {SYM_CELLS{cells_o[SYM_CELLS-1]}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (arm_i || load_i) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/bmc_tx_tail.sv
module bmc_tx_tail #(
  parameter int CNT_W      = 8,
  parameter int TAIL_CELLS = 3
) (
  input  logic [CNT_W-1:0] slot_i,
  input  logic             edge_i,
  output logic             cell_o
);
  localparam logic [CNT_W-1:0] ZERO_SLOT = CNT_W'(TAIL_CELLS - 1);

  // optional high cells first, the last slot always low
  assign cell_o = edge_i && (slot_i < ZERO_SLOT);
endmodule

// File: rtl/bmc_tx_serializer.sv
module bmc_tx_serializer #(
  parameter int         SYM_CELLS  = 10,
  parameter int         PRE_CELLS  = 128,
  parameter int         PAT_W      = 8,
  parameter logic [7:0] PRE_PAT    = 8'hB4,
  parameter int         TAIL_CELLS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cell_tick_i,
  input  logic                 rx_busy_i,
  input  logic                 start_i,
  output logic                 start_rej_o,
  input  logic                 sym_valid_i,
  input  logic [SYM_CELLS-1:0] sym_cells_i,
  output logic                 sym_ready_o,
  input  logic                 eof_i,
  output logic                 tx_line_o,
  output logic                 tx_oe_o
);
  import bmc_tx_pkg::*;

  localparam int               CNT_W     = $clog2(PRE_CELLS + SYM_CELLS + TAIL_CELLS + 1);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CELLS - 1);
  localparam logic [CNT_W-1:0] SYM_LAST  = CNT_W'(SYM_CELLS - 1);
  localparam logic [CNT_W-1:0] TAIL_END  = CNT_W'(TAIL_CELLS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  tx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [SYM_CELLS-1:0] sh_q, sh_d;
  logic                 held_q, held_d;
  logic                 edge_q, edge_d;
  logic                 line_q, line_d;
  logic                 oe_q, oe_d;
  logic                 rej_q, rej_d;
  logic                 arm, load;
  logic                 pre_cell, tail_cell, last_hi;
  logic [SYM_CELLS-1:0] fixed_cells;

  bmc_tx_preamble #(
    .CNT_W (CNT_W),
    .PAT_W (PAT_W),
    .PAT   (PRE_PAT)
  ) u_pre (
    .idx_i  (cnt_q),
    .cell_o (pre_cell)
  );

  bmc_tx_polarity #(
    .SYM_CELLS (SYM_CELLS)
  ) u_pol (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .arm_i     (arm),
    .load_i    (load),
    .raw_i     (sym_cells_i),
    .cells_o   (fixed_cells),
    .last_hi_o (last_hi)
  );

  bmc_tx_tail #(
    .CNT_W      (CNT_W),
    .TAIL_CELLS (TAIL_CELLS)
  ) u_tail (
    .slot_i (cnt_q),
    .edge_i (edge_q),
    .cell_o (tail_cell)
  );

  assign sym_ready_o = (state_q == ST_SYM) && !held_q;
  assign tx_line_o   = line_q;
  assign tx_oe_o     = oe_q;
  assign start_rej_o = rej_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    held_d  = held_q;
    edge_d  = edge_q;
    line_d  = line_q;
    oe_d    = oe_q;
    rej_d   = 1'b0;
    arm     = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (rx_busy_i) begin
            rej_d = 1'b1;
          end else begin
            state_d = ST_PRE;
            cnt_d   = '0;
            arm     = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (cell_tick_i) begin
          line_d = pre_cell;
          oe_d   = 1'b1;
          if (cnt_q == PRE_LAST) begin
            state_d = ST_SYM;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_SYM: begin
        if (held_q) begin
          if (cell_tick_i) begin
            line_d = sh_q[0];
            sh_d   = sh_q >> 1;
            if (cnt_q == SYM_LAST) begin
              held_d = 1'b0;
              cnt_d  = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end else if (sym_valid_i) begin
          load   = 1'b1;
          sh_d   = fixed_cells;
          held_d = 1'b1;
          cnt_d  = '0;
        end else if (eof_i) begin
          state_d = ST_TAIL;
          cnt_d   = '0;
          edge_d  = !last_hi;
        end
      end
      ST_TAIL: begin
        if (cell_tick_i) begin
          if (cnt_q == TAIL_END) begin
            line_d  = 1'b0;
            oe_d    = 1'b0;
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            line_d = tail_cell;
            cnt_d  = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      held_q  <= 1'b0;
      edge_q  <= 1'b0;
      line_q  <= 1'b0;
      oe_q    <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      held_q  <= held_d;
      edge_q  <= edge_d;
      line_q  <= line_d;
      oe_q    <= oe_d;
      rej_q   <= rej_d;
    end
  end
endmodule

// File: rtl/bmc_tx_chk.sv
module bmc_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cell_tick_i,
  input logic sym_valid_i,
  input logic sym_ready_o,
  input logic tx_line_o,
  input logic tx_oe_o,
  input logic start_rej_o
);
  // R9
  line_only_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_tick_i |=> $stable(tx_line_o));

  // R4
  ready_drops_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && sym_ready_o) |=> !sym_ready_o);

  // R4
  ready_only_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_ready_o |-> tx_oe_o);

  // R2
  reject_keeps_line_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rej_o |-> !tx_oe_o);

  // R3
  frame_opens_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> !tx_line_o);

  // R8
  release_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_oe_o) |-> !tx_line_o);
endmodule

bind bmc_tx_serializer bmc_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cell_tick_i (cell_tick_i),
  .sym_valid_i (sym_valid_i),
  .sym_ready_o (sym_ready_o),
  .tx_line_o   (tx_line_o),
  .tx_oe_o     (tx_oe_o),
  .start_rej_o (start_rej_o)
);

// File: tb/bmc_tx_serializer_tb.sv
module bmc_tx_serializer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cell_tick_i = 1'b0;
  logic       rx_busy_i = 1'b0;
  logic       start_i = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [9:0] sym_cells_i = '0;
  logic       eof_i = 1'b0;
  logic       start_rej_o, sym_ready_o, tx_line_o, tx_oe_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic cap [0:1023];
  int   cap_n = 0;
  bit   cap_en = 0;
  int   stable_err = 0;
  logic last_line = 1'b0;
  logic [9:0] syms [0:7];

  bmc_tx_serializer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cell_tick_i(cell_tick_i), .rx_busy_i(rx_busy_i),
    .start_i(start_i), .start_rej_o(start_rej_o), .sym_valid_i(sym_valid_i),
    .sym_cells_i(sym_cells_i), .sym_ready_o(sym_ready_o), .eof_i(eof_i),
    .tx_line_o(tx_line_o), .tx_oe_o(tx_oe_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cell enable: one pulse every fourth clock
  initial begin
    int div = 0;
    forever begin
      @(negedge clk_i);
      div++;
      cell_tick_i = (div % 4 == 0);
    end
  end

  // cell capture and line stability monitor
  initial begin
    forever begin
      logic t;
      @(posedge clk_i);
      t = cell_tick_i;
      #1;
      if (t && tx_oe_o && cap_en && cap_n < 1024) begin
        cap[cap_n] = tx_line_o;
        cap_n++;
      end
      if (!t && rst_ni && tx_line_o !== last_line) stable_err++;
      last_line = tx_line_o;
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic t_reset();
    @(negedge clk_i);
    chk(tx_line_o == 0 && tx_oe_o == 0, "R1 line/oe", {tx_line_o, tx_oe_o}, 0);
    chk(sym_ready_o == 0 && start_rej_o == 0, "R1 ready/rej", {sym_ready_o, start_rej_o}, 0);
  endtask

  task automatic t_reject();
    rx_busy_i = 1;
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
    chk(start_rej_o == 1, "R2 reject pulse", start_rej_o, 1);
    @(negedge clk_i);
    chk(start_rej_o == 0, "R2 reject one cycle", start_rej_o, 0);
    repeat (40) @(negedge clk_i);
    chk(tx_oe_o == 0 && tx_line_o == 0, "R2 line untouched", {tx_oe_o, tx_line_o}, 0);
    rx_busy_i = 0;
  endtask

  task automatic t_frame(input int n, input bit eof_early, input string tag);
    logic exp [0:1023];
    int   en = 0;
    logic [9:0] mask = '1;
    logic [9:0] tx;
    int   bad;
    cap_n = 0;
    stable_err = 0;
    cap_en = 1;
    for (int i = 0; i < 128; i++) begin
      exp[en] = 8'hB4 >> (i % 8);
      en++;
    end
    for (int k = 0; k < n; k++) begin
      tx = syms[k] ^ mask;
      for (int b = 0; b < 10; b++) begin
        exp[en] = tx[b];
        en++;
      end
      mask = tx[9] ? '1 : '0;
    end
    for (int s = 0; s < 3; s++) begin
      exp[en] = (mask[0] == 0) && (s < 2);
      en++;
    end

    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
    repeat (40) @(negedge clk_i);
    chk(sym_ready_o == 0, {tag, " R4 no ready in preamble"}, sym_ready_o, 0);
    chk(tx_oe_o == 1, {tag, " R3 oe during preamble"}, tx_oe_o, 1);
    if (n == 0 || eof_early) eof_i = 1;
    for (int k = 0; k < n; k++) begin
      sym_valid_i = 1;
      sym_cells_i = syms[k];
      while (!sym_ready_o) @(negedge clk_i);
      @(negedge clk_i);
      sym_valid_i = 0;
      chk(sym_ready_o == 0, {tag, " R4 ready drops"}, sym_ready_o, 0);
    end
    eof_i = 1;
    while (tx_oe_o) @(negedge clk_i);
    eof_i = 0;
    cap_en = 0;
    chk(tx_line_o == 0 && sym_ready_o == 0, {tag, " R8 released idle"}, {tx_line_o, sym_ready_o}, 0);
    chk(cap_n == en, {tag, " R8 R10 cell count"}, cap_n, en);
    bad = 0;
    for (int i = 0; i < 128; i++) if (cap[i] !== exp[i]) bad++;
    chk(bad == 0, {tag, " R3 preamble cells"}, bad, 0);
    bad = 0;
    for (int i = 128; i < 138 && i < en - 3; i++) if (cap[i] !== exp[i]) bad++;
    chk(bad == 0, {tag, " R5 first symbol"}, bad, 0);
    bad = 0;
    for (int i = 138; i < en - 3; i++) if (cap[i] !== exp[i]) bad++;
    chk(bad == 0, {tag, " R6 later symbols"}, bad, 0);
    bad = 0;
    for (int i = en - 3; i < en; i++) if (cap[i] !== exp[i]) bad++;
    chk(bad == 0, {tag, " R7 closing cells"}, bad, 0);
    chk(stable_err == 0, {tag, " R9 line between ticks"}, stable_err, 0);
    repeat (10) @(negedge clk_i);
  endtask

  initial begin
    #12 rst_ni = 1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_reject();
    // one symbol ending high: closing 0,0,0
    syms[0] = 10'h155;
    t_frame(1, 0, "A");
    // second symbol ends low: closing 1,1,0
    syms[0] = 10'h000; syms[1] = 10'h3FF;
    t_frame(2, 0, "B");
    // empty frame straight after preamble
    t_frame(0, 0, "C");
    // mixed patterns, end request raised early (R10)
    syms[0] = 10'h2D3; syms[1] = 10'h0F0; syms[2] = 10'h1A5; syms[3] = 10'h33C;
    t_frame(4, 1, "D");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule